// File: doc/BRIEF.md
# Two-Master Mailbox with Guarded Semaphore

This block is a 512-location byte mailbox placed between an on-chip processor bus and an external control port. Both masters use simple single-cycle read and write strobes on one shared clock. The mailbox holds two command bytes, one for each direction, and a flag for each that says a command is waiting. It also holds a general message buffer and a 2-bit semaphore that software uses to claim the buffer before it exchanges messages.

The semaphore is guarded. A write to it does not store the raw value. Instead, the written code and the identity of the writer decide the next state. Each side confirms a claim or a release by reading the location back after the write. Two configuration bytes sit above the shared window and only the internal side can reach them. One of them gates two level interrupts: one toward the internal processor when a receive command is waiting, and one toward the external controller when a transmit command is waiting.

Top module: `mbox_top`

## Requirements
- R1: The message buffer occupies mailbox addresses 0x005 to 0x1FF. A byte written there by either side reads back the same from either side.
- R2: The transmit command byte sits at 0x000 and the receive command byte at 0x001. Either side can write and read both.
- R3: A write to 0x000 sets the transmit-waiting flag (address 0x002, bit 0). A write to 0x001 sets the receive-waiting flag (address 0x003, bit 0). A write to a flag address loads bit 0 of the write data into that flag, so writing 0 clears it. If a command write and a flag write hit the same flag in one cycle, the flag is set.
- R4: The semaphore sits at 0x004 and reads as 00 when free, 01 when the internal side holds it, and 11 when the external side holds it. A claim is a write of 01 from the internal side or of 11 from the external side. A claim takes a free semaphore.
- R5: A claim made while the semaphore is already held leaves its value unchanged.
- R6: A write of 00 frees the semaphore only when the writer is the current holder. A write of 00 from the other side, or while the semaphore is free, changes nothing.
- R7: Any other code written to 0x004 is ignored. This covers 10 from either side, 11 from the internal side and 01 from the external side.
- R8: The internal side reaches a status-control byte at 0x200 and an interrupt-control byte at 0x201, both readable and writable. The external port has only a 9-bit address, so it cannot reach them. Internal reads of 0x202 and above return 0.
- R9: `irq_int` is high while the receive-waiting flag is set and interrupt-control bit 0 is 1. `irq_ext` is high while the transmit-waiting flag is set and interrupt-control bit 1 is 1. Both are level outputs.
- R10: When both sides write the semaphore in the same cycle, the internal write is applied first and the external write is then judged against that result.
- R11: After reset, the command bytes, flags, semaphore and configuration bytes are 0, both interrupts are low and both read-data outputs are 0.
- R12: Read data appears on the side's read-data output on the clock edge that samples the read strobe, and it holds until the next read.
- R13: When both sides write the same buffer byte in one cycle, the internal value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_wr | input | 1 | Internal write strobe |
| int_rd | input | 1 | Internal read strobe |
| int_addr | input | 10 | Internal address; bit 9 selects the configuration bytes |
| int_wdata | input | 8 | Internal write data |
| int_rdata | output | 8 | Internal read data |
| ext_wr | input | 1 | External write strobe |
| ext_rd | input | 1 | External read strobe |
| ext_addr | input | 9 | External address |
| ext_wdata | input | 8 | External write data |
| ext_rdata | output | 8 | External read data |
| irq_int | output | 1 | Level interrupt toward the internal processor |
| irq_ext | output | 1 | Level interrupt toward the external controller |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a semaphore write from the internal side and one from the external side. The second pair is two writes to one storage location, either the same buffer byte, or a command byte together with the flag it sets. The bench drives both strobes in one cycle and covers these cases: both sides claim a free semaphore, the holder releases while the other side claims, and the non-holder claims while the holder releases. It also drives two values into one buffer byte in one cycle. It judges each case by reading the location back through the normal port and comparing against the serve-internal-first order.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam logic [1:0] SEM_FREE = 2'b00;
   localparam logic [1:0] SEM_INT  = 2'b01;
   localparam logic [1:0] SEM_EXT  = 2'b11;

   // next semaphore value for one write by one side
   function automatic logic [1:0] sem_step(input logic [1:0] cur,
                                           input logic       from_ext,
                                           input logic [1:0] code);
      logic [1:0] own;
      own = from_ext ? SEM_EXT : SEM_INT;
      if (code == own)
         sem_step = (cur == SEM_FREE) ? own : cur;
      else if (code == SEM_FREE)
         sem_step = (cur == own) ? SEM_FREE : cur;
      else
         sem_step = cur;
   endfunction
endpackage

// File: rtl/mbox_sema.sv
module mbox_sema
   import mbox_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       i_we,
   input  logic [1:0] i_code,
   input  logic       e_we,
   input  logic [1:0] e_code,
   output logic [1:0] sem
);
   logic [1:0] after_int, after_ext;

   always_comb begin
      after_int = i_we ? sem_step(sem, 1'b0, i_code) : sem;
      after_ext = e_we ? sem_step(after_int, 1'b1, e_code) : after_int;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sem <= SEM_FREE;
      else        sem <= after_ext;
   end
endmodule

// File: rtl/mbox_cmd.sv
module mbox_cmd #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    i_cmd_we,
   input  logic [1:0]    i_flg_we,
   input  logic [DW-1:0] i_wd,
   input  logic [1:0]    e_cmd_we,
   input  logic [1:0]    e_flg_we,
   input  logic [DW-1:0] e_wd,
   output logic [DW-1:0] cmd [2],
   output logic [1:0]    flg
);
   for (genvar k = 0; k < 2; k++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd[k] <= '0;
            flg[k] <= 1'b0;
         end else begin
            if (i_cmd_we[k])      cmd[k] <= i_wd;
            else if (e_cmd_we[k]) cmd[k] <= e_wd;
            if (i_cmd_we[k] || e_cmd_we[k]) flg[k] <= 1'b1;
            else if (i_flg_we[k])           flg[k] <= i_wd[0];
            else if (e_flg_we[k])           flg[k] <= e_wd[0];
         end
      end
   end
endmodule

// File: rtl/mbox_buf.sv
module mbox_buf #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          i_we,
   input  logic [AW-1:0] i_a,
   input  logic [DW-1:0] i_wd,
   output logic [DW-1:0] i_rd,
   input  logic          e_we,
   input  logic [AW-1:0] e_a,
   input  logic [DW-1:0] e_wd,
   output logic [DW-1:0] e_rd
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (e_we) mem[e_a] <= e_wd;
      if (i_we) mem[i_a] <= i_wd;   // internal wins on a shared byte
   end

   assign i_rd = mem[i_a];
   assign e_rd = mem[e_a];
endmodule

// File: rtl/mbox_top.sv
module mbox_top
   import mbox_pkg::*;
#(
   parameter int AW        = 9,
   parameter int DW        = 8,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          int_wr,
   input  logic          int_rd,
   input  logic [AW:0]   int_addr,
   input  logic [DW-1:0] int_wdata,
   output logic [DW-1:0] int_rdata,
   input  logic          ext_wr,
   input  logic          ext_rd,
   input  logic [AW-1:0] ext_addr,
   input  logic [DW-1:0] ext_wdata,
   output logic [DW-1:0] ext_rdata,
   output logic          irq_int,
   output logic          irq_ext
);
   localparam logic [AW-1:0] AD_TXC = AW'(0);
   localparam logic [AW-1:0] AD_RXC = AW'(1);
   localparam logic [AW-1:0] AD_TXF = AW'(2);
   localparam logic [AW-1:0] AD_RXF = AW'(3);
   localparam logic [AW-1:0] AD_SEM = AW'(4);
   localparam logic [AW-1:0] AD_BUF = AW'(5);
   localparam logic [AW-1:0] AD_SCT = AW'(0);
   localparam logic [AW-1:0] AD_ICT = AW'(1);

   if (DW < 2) begin : g_bad_dw
      $error("mbox_top: DW must be at least 2");
   end
   if (AW < 3) begin : g_bad_aw
      $error("mbox_top: AW must be at least 3");
   end

   logic [AW-1:0] i_lo;
   logic          i_hi, i_mb_wr, e_mb_wr;
   logic [1:0]    i_cmd_we, i_flg_we, e_cmd_we, e_flg_we;
   logic [DW-1:0] cmd_q [2];
   logic [1:0]    flag_q, sem_q;
   logic [DW-1:0] sctl_q, ictl_q;
   logic [DW-1:0] buf_i, buf_e, i_mux, e_mux;

   assign i_lo    = int_addr[AW-1:0];
   assign i_hi    = int_addr[AW];
   assign i_mb_wr = int_wr && !i_hi;
   assign e_mb_wr = ext_wr;

   always_comb begin
      i_cmd_we = {i_mb_wr && i_lo == AD_RXC, i_mb_wr && i_lo == AD_TXC};
      i_flg_we = {i_mb_wr && i_lo == AD_RXF, i_mb_wr && i_lo == AD_TXF};
      e_cmd_we = {e_mb_wr && ext_addr == AD_RXC, e_mb_wr && ext_addr == AD_TXC};
      e_flg_we = {e_mb_wr && ext_addr == AD_RXF, e_mb_wr && ext_addr == AD_TXF};
   end

   mbox_cmd #(.DW(DW)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .i_cmd_we(i_cmd_we), .i_flg_we(i_flg_we), .i_wd(int_wdata),
      .e_cmd_we(e_cmd_we), .e_flg_we(e_flg_we), .e_wd(ext_wdata),
      .cmd(cmd_q), .flg(flag_q)
   );

   mbox_sema u_sema (
      .clk(clk), .rst_n(rst_n),
      .i_we(i_mb_wr && i_lo == AD_SEM), .i_code(int_wdata[1:0]),
      .e_we(e_mb_wr && ext_addr == AD_SEM), .e_code(ext_wdata[1:0]),
      .sem(sem_q)
   );

   mbox_buf #(.AW(AW), .DW(DW)) u_buf (
      .clk(clk),
      .i_we(i_mb_wr && i_lo >= AD_BUF), .i_a(i_lo), .i_wd(int_wdata), .i_rd(buf_i),
      .e_we(e_mb_wr && ext_addr >= AD_BUF), .e_a(ext_addr), .e_wd(ext_wdata), .e_rd(buf_e)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sctl_q <= '0;
         ictl_q <= '0;
      end else if (int_wr && i_hi) begin
         if (i_lo == AD_SCT) sctl_q <= int_wdata;
         if (i_lo == AD_ICT) ictl_q <= int_wdata;
      end
   end

   assign irq_int = flag_q[1] && ictl_q[0];
   assign irq_ext = flag_q[0] && ictl_q[1];

   always_comb begin
      if (i_hi) begin
         if (i_lo == AD_SCT)      i_mux = sctl_q;
         else if (i_lo == AD_ICT) i_mux = ictl_q;
         else                     i_mux = '0;
      end else begin
         case (i_lo)
            AD_TXC:  i_mux = cmd_q[0];
            AD_RXC:  i_mux = cmd_q[1];
            AD_TXF:  i_mux = {{(DW-1){1'b0}}, flag_q[0]};
            AD_RXF:  i_mux = {{(DW-1){1'b0}}, flag_q[1]};
            AD_SEM:  i_mux = {{(DW-2){1'b0}}, sem_q};
            default: i_mux = buf_i;
         endcase
      end
   end

   always_comb begin
      case (ext_addr)
         AD_TXC:  e_mux = cmd_q[0];
         AD_RXC:  e_mux = cmd_q[1];
         AD_TXF:  e_mux = {{(DW-1){1'b0}}, flag_q[0]};
         AD_RXF:  e_mux = {{(DW-1){1'b0}}, flag_q[1]};
         AD_SEM:  e_mux = {{(DW-2){1'b0}}, sem_q};
         default: e_mux = buf_e;
      endcase
   end

   if (REG_RDATA) begin : g_rd_reg
      logic [DW-1:0] i_rq, e_rq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            i_rq <= '0;
            e_rq <= '0;
         end else begin
            if (int_rd) i_rq <= i_mux;
            if (ext_rd) e_rq <= e_mux;
         end
      end
      assign int_rdata = i_rq;
      assign ext_rdata = e_rq;
   end else begin : g_rd_comb
      assign int_rdata = int_rd ? i_mux : '0;
      assign ext_rdata = ext_rd ? e_mux : '0;
   end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
   parameter int AW = 9,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          int_wr,
   input logic [AW:0]   int_addr,
   input logic [DW-1:0] int_wdata,
   input logic          ext_wr,
   input logic [AW-1:0] ext_addr,
   input logic [DW-1:0] ext_wdata,
   input logic          irq_ext,
   input logic [1:0]    sem,
   input logic [1:0]    flags,
   input logic [1:0]    ien
);
   logic i_sem_wr, e_sem_wr;
   assign i_sem_wr = int_wr && int_addr == (AW+1)'(4);
   assign e_sem_wr = ext_wr && ext_addr == AW'(4);

   a_r7_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      sem != 2'b10);

   a_r4_int_claim: assert property (@(posedge clk) disable iff (!rst_n)
      (sem == 2'b00 && i_sem_wr && int_wdata[1:0] == 2'b01) |=> sem == 2'b01);

   a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sem == 2'b11 && !e_sem_wr) |=> sem == 2'b11);

   a_r3_rx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && ext_addr == AW'(1)) |=> flags[1]);

   a_r9_ext_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr && ext_addr == AW'(0) && ien[1] && !(int_wr && int_addr[AW]))
      |=> irq_ext);

   a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_wr && int_addr[AW]) |=> $stable(ien));
endmodule

bind mbox_top mbox_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .int_wr(int_wr), .int_addr(int_addr), .int_wdata(int_wdata),
   .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
   .irq_ext(irq_ext), .sem(sem_q), .flags(flag_q), .ien(ictl_q[1:0])
);

// File: tb/mbox_top_bench.sv
module mbox_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_wr = 0, int_rd = 0, ext_wr = 0, ext_rd = 0;
   logic [9:0] int_addr = '0;
   logic [8:0] ext_addr = '0;
   logic [7:0] int_wdata = '0, ext_wdata = '0;
   logic [7:0] int_rdata, ext_rdata;
   logic       irq_int, irq_ext;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 0;

   logic [7:0] q_iexp[$], q_eexp[$];
   string      q_itag[$], q_etag[$];
   logic       p_i = 0, p_e = 0;

   always #2.5 clk = ~clk;

   mbox_top u_mbox_top (
      .clk(clk), .rst_n(rst_n),
      .int_wr(int_wr), .int_rd(int_rd), .int_addr(int_addr),
      .int_wdata(int_wdata), .int_rdata(int_rdata),
      .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .irq_int(irq_int), .irq_ext(irq_ext)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard one cycle after each read strobe (R12)
   always @(posedge clk) begin
      p_i <= int_rd;
      p_e <= ext_rd;
   end
   always @(negedge clk) begin
      if (p_i && q_iexp.size() > 0) check(int_rdata, q_iexp.pop_front(), q_itag.pop_front());
      if (p_e && q_eexp.size() > 0) check(ext_rdata, q_eexp.pop_front(), q_etag.pop_front());
   end

   task automatic iwrite(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk); int_wr = 1; int_addr = a; int_wdata = d;
      @(negedge clk); int_wr = 0;
   endtask
   task automatic ewrite(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk); ext_wr = 1; ext_addr = a; ext_wdata = d;
      @(negedge clk); ext_wr = 0;
   endtask
   task automatic bwrite(input logic [9:0] ia, input logic [7:0] id,
                         input logic [8:0] ea, input logic [7:0] ed);
      @(negedge clk); int_wr = 1; int_addr = ia; int_wdata = id;
      ext_wr = 1; ext_addr = ea; ext_wdata = ed;
      @(negedge clk); int_wr = 0; ext_wr = 0;
   endtask
   task automatic iread(input logic [9:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); int_rd = 1; int_addr = a;
      q_iexp.push_back(exp); q_itag.push_back(tag);
      @(negedge clk); int_rd = 0;
   endtask
   task automatic eread(input logic [8:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); ext_rd = 1; ext_addr = a;
      q_eexp.push_back(exp); q_etag.push_back(tag);
      @(negedge clk); ext_rd = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_chk++; n_err++;
         $display("FAIL R12 watchdog actual=%0d expected<=20000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check({7'b0, irq_int}, 8'h00, "R11 irq_int");
      check({7'b0, irq_ext}, 8'h00, "R11 irq_ext");
      check(int_rdata, 8'h00, "R11 int_rdata");
      check(ext_rdata, 8'h00, "R11 ext_rdata");
      rst_n = 1;
      iread(10'h004, 8'h00, "R11 sem free");
      iread(10'h002, 8'h00, "R11 tx flag");
      // R1 buffer both directions
      iwrite(10'h005, 8'hA5);
      eread(9'h005, 8'hA5, "R1 low byte");
      ewrite(9'h1FF, 8'h3C);
      iread(10'h1FF, 8'h3C, "R1 top byte");
      // R2/R3/R9 commands, flags, interrupts
      iwrite(10'h000, 8'h11);
      eread(9'h000, 8'h11, "R2 tx cmd");
      eread(9'h002, 8'h01, "R3 tx flag set");
      check({7'b0, irq_ext}, 8'h00, "R9 masked");
      iwrite(10'h201, 8'h03);
      check({7'b0, irq_ext}, 8'h01, "R9 irq_ext");
      check({7'b0, irq_int}, 8'h00, "R9 irq_int idle");
      ewrite(9'h001, 8'h22);
      check({7'b0, irq_int}, 8'h01, "R9 irq_int");
      iread(10'h001, 8'h22, "R2 rx cmd");
      ewrite(9'h002, 8'h00);
      check({7'b0, irq_ext}, 8'h00, "R3 tx clear");
      iwrite(10'h003, 8'h00);
      check({7'b0, irq_int}, 8'h00, "R3 rx clear");
      // R8 internal-only configuration
      iread(10'h201, 8'h03, "R8 ictl");
      iwrite(10'h200, 8'h5A);
      iread(10'h200, 8'h5A, "R8 sctl");
      iread(10'h202, 8'h00, "R8 unused");
      ewrite(9'h000, 8'h77);
      iread(10'h200, 8'h5A, "R8 ext cannot reach");
      ewrite(9'h002, 8'h00);
      // semaphore R4 R5 R6 R7
      iwrite(10'h004, 8'h01);
      iread(10'h004, 8'h01, "R4 int claim");
      ewrite(9'h004, 8'h03);
      eread(9'h004, 8'h01, "R5 ext claim refused");
      ewrite(9'h004, 8'h00);
      iread(10'h004, 8'h01, "R6 non-holder release");
      iwrite(10'h004, 8'h02);
      iread(10'h004, 8'h01, "R7 code 10");
      iwrite(10'h004, 8'h00);
      iread(10'h004, 8'h00, "R6 holder release");
      ewrite(9'h004, 8'h00);
      eread(9'h004, 8'h00, "R6 release while free");
      iwrite(10'h004, 8'h03);
      iread(10'h004, 8'h00, "R7 int writes 11");
      ewrite(9'h004, 8'h01);
      eread(9'h004, 8'h00, "R7 ext writes 01");
      ewrite(9'h004, 8'h03);
      eread(9'h004, 8'h03, "R4 ext claim");
      iwrite(10'h004, 8'h01);
      iread(10'h004, 8'h03, "R5 int claim refused");
      ewrite(9'h004, 8'h00);
      // R10 same-cycle semaphore writes
      bwrite(10'h004, 8'h01, 9'h004, 8'h03);
      iread(10'h004, 8'h01, "R10 both claim");
      bwrite(10'h004, 8'h00, 9'h004, 8'h03);
      eread(9'h004, 8'h03, "R10 release then claim");
      bwrite(10'h004, 8'h01, 9'h004, 8'h00);
      iread(10'h004, 8'h00, "R10 claim then release");
      // R13 buffer collision, R3 parallel command writes
      bwrite(10'h010, 8'hAA, 9'h010, 8'h55);
      eread(9'h010, 8'hAA, "R13 internal kept");
      bwrite(10'h000, 8'h01, 9'h001, 8'h02);
      check({6'b0, irq_int, irq_ext}, 8'h03, "R3 both flags");
      bwrite(10'h002, 8'h00, 9'h000, 8'h09);
      eread(9'h002, 8'h01, "R3 set beats clear");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule